// File: doc/BRIEF.md
# Adaptive Hysteresis Threshold Finder

This block chooses the two hysteresis thresholds of an edge detector from the data of each frame, so the thresholds need not be set by hand. It sees the gradient magnitudes that survive non-maximum suppression, one per cycle, framed by a start strobe and an end strobe. While a frame is open it counts how many non-zero magnitudes fall on each value. These counts form a histogram held in a bank of saturating counters.

When the frame closes, a scan walks the histogram upward from the first counted bin. Each cycle it compares one bin with the next. The first bin whose count equals its upper neighbour marks the flat region between the background peak and the first edge peak. That bin index becomes the high threshold, and half of it, rounded down, becomes the low threshold. A one-cycle done pulse announces the pair. The thresholds then hold until the next result.

Top module: `canny_auto_thresh`

## Requirements
- R1: While a frame is open, every cycle with `mag_valid_i` high and a non-zero magnitude adds one to the bin whose index equals the magnitude.
- R2: A magnitude of zero changes no bin.
- R3: A magnitude of NUM_BINS (100) or more is counted in the top bin, index NUM_BINS-1.
- R4: A bin count saturates at 2^CNT_W-1 (4095) and stays there for further pixels, without wrapping.
- R5: `frame_start_i` clears every bin and opens a new frame. A pixel presented in that same cycle is not counted. A start that arrives during a scan abandons it, and no done pulse follows.
- R6: After `frame_end_i` is sampled, the scan compares bin k with bin k+1 for k = 1, 2, … in ascending order, one k per cycle. The high threshold is the first k whose two counts are equal, and `thr_done_o` rises exactly k cycles after the edge that sampled the end strobe.
- R7: If no equal pair exists up to k = NUM_BINS-2, the high threshold is NUM_BINS-1 (99), and done still rises NUM_BINS-2 (98) cycles after the end edge.
- R8: The low threshold equals the high threshold shifted right by one bit.
- R9: After reset, `thr_done_o` is 0 and both thresholds are 0. Done is a single-cycle pulse. The thresholds change only in the cycle done is high and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Clears the histogram and opens a frame |
| frame_end_i | input | 1 | Closes the frame and starts the scan |
| mag_valid_i | input | 1 | Qualifies `mag_i` |
| mag_i | input | MAG_W (8) | Suppressed gradient magnitude |
| thr_high_o | output | MAG_W (8) | High hysteresis threshold |
| thr_low_o | output | MAG_W (8) | Low hysteresis threshold |
| thr_done_o | output | 1 | One-cycle pulse when a new pair is ready |

## Verification
The assertions check these properties on every cycle:
- A saturated bin never moves except on clear.
- A clear empties every bin.
- Only legal indices are ever incremented.
- Done is a pulse that appears only after a scan.
- The low threshold is half the high one.
- Both thresholds stay stable between results.

Other behaviours depend on whole frames, and only the bench scenarios show them:
- the found index matching a software histogram search;
- the exact scan latency;
- out-of-range magnitudes folding into the top bin;
- zero magnitudes being left out;
- a pixel dropped when it arrives with the start strobe;
- a scan abandoned by an early start.

// File: rtl/cat_pkg.sv
package cat_pkg;

  typedef enum logic [1:0] {
    CT_IDLE    = 2'd0,
    CT_COLLECT = 2'd1,
    CT_SCAN    = 2'd2
  } cat_state_e;

endpackage

// File: rtl/cat_bin_router.sv
module cat_bin_router #(
  parameter int NUM_BINS = 100,
  parameter int MAG_W    = 8,
  localparam int IDX_W   = $clog2(NUM_BINS)
) (
  input  logic             collecting_i,
  input  logic             mag_valid_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic             inc_o,
  output logic [IDX_W-1:0] inc_idx_o
);

  localparam logic [MAG_W-1:0] TOP_MAG = MAG_W'(NUM_BINS - 1);

  logic over_range;

  always_comb begin
    over_range = (mag_i > TOP_MAG);
    inc_o      = collecting_i && mag_valid_i && (mag_i != '0);
    if (over_range) begin
      inc_idx_o = IDX_W'(NUM_BINS - 1);
    end else begin
      inc_idx_o = mag_i[IDX_W-1:0];
    end
  end

endmodule

// File: rtl/cat_hist_bank.sv
module cat_hist_bank #(
  parameter int NUM_BINS = 100,
  parameter int CNT_W    = 12,
  localparam int IDX_W   = $clog2(NUM_BINS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [IDX_W-1:0] inc_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_lo_o,
  output logic [CNT_W-1:0] rd_hi_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] bin_val [NUM_BINS];
  logic [IDX_W-1:0] rd_nxt;

  AST_INC_LEGAL_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> (inc_idx_i != '0) && (inc_idx_i <= IDX_W'(NUM_BINS - 1))); // R2 R3

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             hit;
    logic             cnt_en;

    always_comb begin
      hit    = inc_i && (inc_idx_i == IDX_W'(b)) && (cnt_q != CNT_MAX);
      cnt_en = clr_i || hit;
      if (clr_i) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
      end else if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end

    assign bin_val[b] = cnt_q;

    AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == CNT_MAX) && !clr_i |=> (cnt_q == CNT_MAX)); // R4

    AST_CLEAR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0)); // R5
  end

  always_comb begin
    rd_nxt  = rd_idx_i + 1'b1;
    rd_lo_o = '0;
    rd_hi_o = '0;
    for (int b = 0; b < NUM_BINS; b++) begin
      if (rd_idx_i == IDX_W'(b)) rd_lo_o = bin_val[b];
      if (rd_nxt == IDX_W'(b))   rd_hi_o = bin_val[b];
    end
  end

endmodule

// File: rtl/cat_scan_ctrl.sv
module cat_scan_ctrl
  import cat_pkg::*;
#(
  parameter int NUM_BINS = 100,
  parameter int CNT_W    = 12,
  parameter int MAG_W    = 8,
  localparam int IDX_W   = $clog2(NUM_BINS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic             frame_end_i,
  input  logic [CNT_W-1:0] rd_lo_i,
  input  logic [CNT_W-1:0] rd_hi_i,
  output logic             collecting_o,
  output logic             clr_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic [MAG_W-1:0] thr_high_o,
  output logic [MAG_W-1:0] thr_low_o,
  output logic             done_o
);

  localparam logic [IDX_W-1:0] LAST_K   = IDX_W'(NUM_BINS - 2);
  localparam logic [MAG_W-1:0] TOP_THR  = MAG_W'(NUM_BINS - 1);

  cat_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [MAG_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic             done_q, done_d;
  logic             thr_en, idx_en, pair_equal;

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    idx_en     = 1'b0;
    thr_en     = 1'b0;
    done_d     = 1'b0;
    pair_equal = (rd_lo_i == rd_hi_i);
    hi_d       = hi_q;
    lo_d       = lo_q;
    if (frame_start_i) begin
      state_d = CT_COLLECT;
    end else begin
      unique case (state_q)
        CT_COLLECT: begin
          if (frame_end_i) begin
            state_d = CT_SCAN;
            idx_d   = IDX_W'(1);
            idx_en  = 1'b1;
          end
        end
        CT_SCAN: begin
          if (pair_equal || (idx_q == LAST_K)) begin
            thr_en  = 1'b1;
            done_d  = 1'b1;
            state_d = CT_IDLE;
            hi_d    = pair_equal ? MAG_W'(idx_q) : TOP_THR;
            lo_d    = hi_d >> 1;
          end else begin
            idx_d  = idx_q + 1'b1;
            idx_en = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CT_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (thr_en) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign collecting_o = (state_q == CT_COLLECT);
  assign clr_o        = frame_start_i;
  assign rd_idx_o     = idx_q;
  assign thr_high_o   = hi_q;
  assign thr_low_o    = lo_q;
  assign done_o       = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R9

  AST_DONE_FROM_SCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> ($past(state_q) == CT_SCAN) && !$past(frame_start_i)); // R6

  AST_HIGH_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (hi_q >= MAG_W'(1)) && (hi_q <= TOP_THR)); // R7

  AST_LOW_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (lo_q == (hi_q >> 1))); // R8

  AST_THR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> $stable(hi_q) && $stable(lo_q)); // R9

endmodule

// File: rtl/canny_auto_thresh.sv
module canny_auto_thresh #(
  parameter int NUM_BINS = 100,
  parameter int CNT_W    = 12,
  parameter int MAG_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic             frame_end_i,
  input  logic             mag_valid_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic [MAG_W-1:0] thr_high_o,
  output logic [MAG_W-1:0] thr_low_o,
  output logic             thr_done_o
);

  localparam int IDX_W = $clog2(NUM_BINS);

  logic             collecting;
  logic             clr;
  logic             inc;
  logic [IDX_W-1:0] inc_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [CNT_W-1:0] rd_lo;
  logic [CNT_W-1:0] rd_hi;

  cat_bin_router #(
    .NUM_BINS (NUM_BINS),
    .MAG_W    (MAG_W)
  ) u_router (
    .collecting_i (collecting),
    .mag_valid_i  (mag_valid_i),
    .mag_i        (mag_i),
    .inc_o        (inc),
    .inc_idx_o    (inc_idx)
  );

  cat_hist_bank #(
    .NUM_BINS (NUM_BINS),
    .CNT_W    (CNT_W)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .inc_i     (inc),
    .inc_idx_i (inc_idx),
    .rd_idx_i  (rd_idx),
    .rd_lo_o   (rd_lo),
    .rd_hi_o   (rd_hi)
  );

  cat_scan_ctrl #(
    .NUM_BINS (NUM_BINS),
    .CNT_W    (CNT_W),
    .MAG_W    (MAG_W)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .frame_end_i   (frame_end_i),
    .rd_lo_i       (rd_lo),
    .rd_hi_i       (rd_hi),
    .collecting_o  (collecting),
    .clr_o         (clr),
    .rd_idx_o      (rd_idx),
    .thr_high_o    (thr_high_o),
    .thr_low_o     (thr_low_o),
    .done_o        (thr_done_o)
  );

endmodule

// File: tb/canny_auto_thresh_tb.sv
module canny_auto_thresh_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NB    = 100;
  localparam int CW    = 12;
  localparam int MW    = 8;
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fs = 1'b0;
  logic          fe = 1'b0;
  logic          mv = 1'b0;
  logic [MW-1:0] mg = '0;
  logic [MW-1:0] thr_hi, thr_lo;
  logic          done;

  int checks = 0;
  int fails  = 0;
  int model [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  canny_auto_thresh #(.NUM_BINS(NB), .CNT_W(CW), .MAG_W(MW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .frame_end_i(fe),
    .mag_valid_i(mv), .mag_i(mg), .thr_high_o(thr_hi), .thr_low_o(thr_lo),
    .thr_done_o(done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int find_k();
    for (int k = 1; k <= NB - 2; k++) if (model[k] == model[k+1]) return k;
    return NB - 1;
  endfunction

  function automatic int find_lat();
    for (int k = 1; k <= NB - 2; k++) if (model[k] == model[k+1]) return k;
    return NB - 2;
  endfunction

  task automatic start_frame(input bit with_pixel);
    @(negedge clk);
    fs = 1'b1; mv = with_pixel; mg = MW'(1);
    @(negedge clk);
    fs = 1'b0; mv = 1'b0;
    for (int b = 0; b < NB; b++) model[b] = 0;
  endtask

  task automatic push(input int m);
    int idx;
    mv = 1'b1; mg = MW'(m);
    @(negedge clk);
    mv = 1'b0;
    if (m != 0) begin
      idx = (m >= NB) ? NB - 1 : m;
      if (model[idx] < CMAX) model[idx]++;
    end
  endtask

  task automatic end_and_check(input string req);
    int c;
    int ek;
    bit seen;
    ek = find_k();
    fe = 1'b1;
    @(negedge clk);
    fe = 1'b0;
    c = 0; seen = 1'b0;
    while (!seen && c < 200) begin
      if (done) seen = 1'b1;
      else begin @(negedge clk); c++; end
    end
    check(seen, {req, " done"}, int'(seen), 1);
    check(c == find_lat(), {req, " R6 latency"}, c, find_lat());
    check(int'(thr_hi) == ek, {req, " high"}, int'(thr_hi), ek);
    check(int'(thr_lo) == ek / 2, {req, " R8 low"}, int'(thr_lo), ek / 2);
    @(negedge clk);
    check(!done, {req, " R9 pulse"}, int'(done), 0);
    check(int'(thr_hi) == ek, {req, " R9 hold"}, int'(thr_hi), ek);
  endtask

  initial begin
    #(CLK_PERIOD * 250000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4217));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && thr_hi == 0 && thr_lo == 0, "R9 reset", int'(thr_hi), 0);

    // R6: empty frame -> bins 1 and 2 both zero
    start_frame(1'b0);
    end_and_check("R6 empty");

    // R1 R3 R7: distinct counts, top bin fed only by folded magnitudes
    start_frame(1'b0);
    for (int b = 1; b <= 98; b++) for (int n = 0; n < b; n++) push(b);
    for (int n = 0; n < 99; n++) push(100 + (n % 150));
    end_and_check("R7 R3 distinct");

    // R2: zeros interleaved must not change the result
    start_frame(1'b0);
    for (int n = 0; n < 3; n++) begin push(1); push(0); end
    for (int n = 0; n < 5; n++) begin push(2); push(0); push(3); end
    end_and_check("R2 zeros");

    // R4: saturation makes bins 1 and 2 equal
    start_frame(1'b0);
    for (int n = 0; n < 4100; n++) push(1);
    for (int n = 0; n < 4095; n++) push(2);
    end_and_check("R4 saturate");

    // R5: pixel coinciding with start is dropped
    start_frame(1'b1);
    push(1); push(1);
    for (int n = 0; n < 3; n++) begin push(2); push(3); end
    end_and_check("R5 same-cycle");

    // R5: start during scan abandons it; stale bins cleared
    start_frame(1'b0);
    for (int b = 1; b <= 10; b++) for (int n = 0; n < b; n++) push(b);
    fe = 1'b1; @(negedge clk); fe = 1'b0;
    repeat (3) @(negedge clk);
    start_frame(1'b0);
    begin
      bit any_done = 1'b0;
      for (int n = 0; n < 120; n++) begin
        if (done) any_done = 1'b1;
        @(negedge clk);
      end
      check(!any_done, "R5 abort no done", int'(any_done), 0);
    end
    push(4); push(5); push(5); push(6);
    end_and_check("R5 R1 after abort");

    // R1: random frames
    for (int f = 0; f < 6; f++) begin
      start_frame(1'b0);
      for (int n = 0; n < 400; n++) begin
        if ($urandom_range(0, 9) == 0) push($urandom_range(0, 255));
        else push($urandom_range(0, 20 + 4 * f));
      end
      end_and_check("R1 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule